// File: doc/BRIEF.md
# Doorbell and Interrupt Register File

This block is the small 32-bit register window of a shared-memory device that links several compute nodes. Software on the local node uses it for three things: to mask and inspect local interrupt causes, to learn which node number it has been given, and to ring a doorbell on another node. A doorbell write packs a destination node and a vector number into one word. The block checks that word against a live table of peers that a separate tracker keeps. When the check passes, the block emits a one-clock notification strobe.

Interrupt causes come in from the local side as 8-bit event codes, and each code overwrites the status register. The legacy interrupt line is high while any status bit is also enabled in the mask. Reading the status register hands its value to software and clears it in the same access, so one read both acknowledges and drops the line. The window is 256 bytes and only whole 32-bit words are meaningful.

Top module: `shm_doorbell_regs`

## Requirements
- R1: After reset the mask and status registers are zero, `irq` is low and `notifyValid` is low.
- R2: A read returns the mask at byte offset 0x00, the status at 0x04 and the position value at 0x08, all decoded on the full address. Every other read address returns zero, including the doorbell offset 0x0C and addresses whose low two bits are non-zero.
- R3: For writes the low two address bits are ignored. A write to word 0 loads the mask and a write to word 1 loads the status. Writes to word 2 (position) and to undefined words change no register.
- R4: `irq` is high exactly when the bitwise AND of status and mask is non-zero. It follows each register change one clock after the access or event that made it.
- R5: A status read returns the value held before the access, and the register is zero from the next clock on.
- R6: A local event (`evtValid` high) loads status with `evtData` zero-extended to 32 bits. If a bus status write or a status read falls in the same clock, the event value is what remains.
- R7: A doorbell write goes to word 3. Bits 31:16 give the destination and bits 7:0 give the vector; bits 15:8 are ignored. An accepted doorbell raises `notifyValid` for exactly one clock, starting one clock after the write, with `notifyDest` and `notifyVec` carrying the decoded fields.
- R8: A doorbell whose destination is greater than `maxPeer`, or is not below `NUM_PEERS`, produces no notification.
- R9: A doorbell whose vector is not less than the destination's entry in `peerVecCount` produces no notification. Entry i sits at bits [8i+7:8i], so a count of zero blocks every vector.
- R10: The position read returns `localId` zero-extended when `shmMapped` is high, and 0xFFFFFFFF when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access strobe, one clock per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address inside the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access clock |
| evtValid | input | 1 | Local event strobe |
| evtData | input | 8 | Local event code loaded into status |
| peerVecCount | input | NUM_PEERS*8 | Registered vector count for each peer |
| maxPeer | input | 16 | Highest valid peer number |
| localId | input | 16 | This node's number |
| shmMapped | input | 1 | Shared memory is mapped |
| irq | output | 1 | Level interrupt |
| notifyValid | output | 1 | Doorbell notification strobe |
| notifyDest | output | 16 | Destination node of the notification |
| notifyVec | output | 8 | Vector of the notification |

## Verification
Doorbell words are taken from a table. The entries separate three ways a ring can be dropped: a destination past `maxPeer`, a vector equal to the peer's count, and a peer whose count is zero. These sit next to accepted rings at the last legal vector, and next to rings with junk in bits 15:8 to show those bits are ignored. A further case raises `maxPeer` above the table size, which shows that the table bound is checked on its own. Register tests write with non-zero low address bits, to show the write decode ignores them while the read decode does not. Other cases drive a local event in the same clock as a status write and as a status read, to fix which source wins. Mask and status values are chosen so that some overlap and some do not, which separates the AND that drives `irq` from an OR.

// File: rtl/shm_db_pkg.sv
package shm_db_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int NODE_W = 16;
  localparam int VEC_W  = 8;
  localparam int EVT_W  = 8;
  localparam int WORD_W = ADDR_W - 2;

  localparam logic [WORD_W-1:0] WORD_MASK   = WORD_W'(0);
  localparam logic [WORD_W-1:0] WORD_STATUS = WORD_W'(1);
  localparam logic [WORD_W-1:0] WORD_POS    = WORD_W'(2);
  localparam logic [WORD_W-1:0] WORD_BELL   = WORD_W'(3);

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_MASK   = 2'd1,
    RD_STATUS = 2'd2,
    RD_POS    = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic    wrMask;
    logic    wrStatus;
    logic    clrStatus;
    logic    ringBell;
    rd_sel_e rdSel;
  } reg_strobe_t;

endpackage

// File: rtl/shm_db_ctrl.sv
module shm_db_ctrl
  import shm_db_pkg::*;
#(
  parameter int NUM_PEERS = 8,
  parameter int CNT_W     = 8
) (
  input  logic                       busSel,
  input  logic                       busWrite,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [NODE_W-1:0]          bellDest,
  input  logic [VEC_W-1:0]           bellVec,
  input  logic [NUM_PEERS*CNT_W-1:0] peerVecCount,
  input  logic [NODE_W-1:0]          maxPeer,
  output reg_strobe_t                strobe
);

  localparam int IDX_W = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1;
  localparam int CMP_W = (CNT_W > VEC_W) ? CNT_W : VEC_W;

  logic [CNT_W-1:0] cntTab [NUM_PEERS];

  genvar g;
  generate
    for (g = 0; g < NUM_PEERS; g++) begin : g_cnt
      assign cntTab[g] = peerVecCount[g*CNT_W +: CNT_W];
    end
  endgenerate

  logic [WORD_W-1:0] wordIdx;
  logic              aligned;
  logic              wrEn;
  logic              rdEn;
  logic              destKnown;
  logic              destInTable;
  logic [IDX_W-1:0]  destIdx;
  logic [CMP_W-1:0]  vecWide;
  logic [CMP_W-1:0]  cntWide;
  logic              vecInRange;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign wrEn    = busSel && busWrite;
  assign rdEn    = busSel && !busWrite;

  // Range checks against the live peer table.
  assign destKnown   = (bellDest <= maxPeer);
  assign destInTable = (bellDest < NODE_W'(NUM_PEERS));
  assign destIdx     = bellDest[IDX_W-1:0];

  always_comb begin
    vecWide = CMP_W'(bellVec);
    cntWide = '0;
    if (destInTable) cntWide = CMP_W'(cntTab[destIdx]);
  end

  assign vecInRange = (vecWide < cntWide);

  always_comb begin
    strobe           = '0;
    strobe.rdSel     = RD_ZERO;
    strobe.wrMask    = wrEn && (wordIdx == WORD_MASK);
    strobe.wrStatus  = wrEn && (wordIdx == WORD_STATUS);
    strobe.ringBell  = wrEn && (wordIdx == WORD_BELL) &&
                       destKnown && destInTable && vecInRange;
    strobe.clrStatus = rdEn && aligned && (wordIdx == WORD_STATUS);
    if (rdEn && aligned) begin
      unique case (wordIdx)
        WORD_MASK:   strobe.rdSel = RD_MASK;
        WORD_STATUS: strobe.rdSel = RD_STATUS;
        WORD_POS:    strobe.rdSel = RD_POS;
        default:     strobe.rdSel = RD_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/shm_db_dp.sv
module shm_db_dp
  import shm_db_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  reg_strobe_t       strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              evtValid,
  input  logic [EVT_W-1:0]  evtData,
  input  logic [NODE_W-1:0] localId,
  input  logic              shmMapped,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output logic              notifyValid,
  output logic [NODE_W-1:0] notifyDest,
  output logic [VEC_W-1:0]  notifyVec
);

  logic [DATA_W-1:0] maskQ;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] posVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (strobe.wrMask) begin
      maskQ <= busWdata;
    end
  end

  // Local event has the last word over a bus write or read-clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
    end else if (evtValid) begin
      statusQ <= DATA_W'(evtData);
    end else if (strobe.wrStatus) begin
      statusQ <= busWdata;
    end else if (strobe.clrStatus) begin
      statusQ <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      notifyValid <= 1'b0;
      notifyDest  <= '0;
      notifyVec   <= '0;
    end else begin
      notifyValid <= strobe.ringBell;
      if (strobe.ringBell) begin
        notifyDest <= busWdata[DATA_W-1:DATA_W-NODE_W];
        notifyVec  <= busWdata[VEC_W-1:0];
      end
    end
  end

  assign posVal = shmMapped ? DATA_W'(localId) : '1;

  always_comb begin
    unique case (strobe.rdSel)
      RD_MASK:   busRdata = maskQ;
      RD_STATUS: busRdata = statusQ;
      RD_POS:    busRdata = posVal;
      default:   busRdata = '0;
    endcase
  end

  assign irq = |(statusQ & maskQ);

  // R5: a status read with no competing source leaves status cleared
  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrStatus && !evtValid) |=> (statusQ == '0));

  // R4: an event overlapping the mask raises the line next clock
  p_event_raises_irq_r4: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && (|(DATA_W'(evtData) & maskQ)) && !strobe.wrMask) |=> irq);

  // R6: event value wins over a same-clock status write
  p_event_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && strobe.wrStatus) |=> (statusQ == DATA_W'($past(evtData))));

endmodule

// File: rtl/shm_doorbell_regs.sv
module shm_doorbell_regs
  import shm_db_pkg::*;
#(
  parameter int NUM_PEERS = 8,
  parameter int CNT_W     = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busSel,
  input  logic                       busWrite,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busWdata,
  output logic [DATA_W-1:0]          busRdata,
  input  logic                       evtValid,
  input  logic [EVT_W-1:0]           evtData,
  input  logic [NUM_PEERS*CNT_W-1:0] peerVecCount,
  input  logic [NODE_W-1:0]          maxPeer,
  input  logic [NODE_W-1:0]          localId,
  input  logic                       shmMapped,
  output logic                       irq,
  output logic                       notifyValid,
  output logic [NODE_W-1:0]          notifyDest,
  output logic [VEC_W-1:0]           notifyVec
);

  reg_strobe_t strobe;

  shm_db_ctrl #(
    .NUM_PEERS (NUM_PEERS),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .busSel       (busSel),
    .busWrite     (busWrite),
    .busAddr      (busAddr),
    .bellDest     (busWdata[DATA_W-1:DATA_W-NODE_W]),
    .bellVec      (busWdata[VEC_W-1:0]),
    .peerVecCount (peerVecCount),
    .maxPeer      (maxPeer),
    .strobe       (strobe)
  );

  shm_db_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .busWdata    (busWdata),
    .evtValid    (evtValid),
    .evtData     (evtData),
    .localId     (localId),
    .shmMapped   (shmMapped),
    .busRdata    (busRdata),
    .irq         (irq),
    .notifyValid (notifyValid),
    .notifyDest  (notifyDest),
    .notifyVec   (notifyVec)
  );

  // R7: a notification only ever follows a write to the doorbell word
  p_notify_after_bell_r7: assert property (@(posedge clk) disable iff (!rstN)
    notifyValid |-> $past(busSel && busWrite && (busAddr[ADDR_W-1:2] == WORD_BELL)));

  // R8: a destination past the highest peer never notifies
  p_far_dest_dropped_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && (busAddr[ADDR_W-1:2] == WORD_BELL) &&
     (busWdata[DATA_W-1:DATA_W-NODE_W] > maxPeer)) |=> !notifyValid);

  // R10: unmapped position read returns all ones
  p_pos_unmapped_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && (busAddr == 8'h08) && !shmMapped) |-> (busRdata == '1));

endmodule

// File: tb/shm_doorbell_regs_test.sv
module shm_doorbell_regs_test;

  localparam int NP = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          busSel;
  logic          busWrite;
  logic [7:0]    busAddr;
  logic [31:0]   busWdata;
  logic [31:0]   busRdata;
  logic          evtValid;
  logic [7:0]    evtData;
  logic [NP*CW-1:0] peerVecCount;
  logic [15:0]   maxPeer;
  logic [15:0]   localId;
  logic          shmMapped;
  logic          irq;
  logic          notifyValid;
  logic [15:0]   notifyDest;
  logic [7:0]    notifyVec;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  shm_doorbell_regs #(.NUM_PEERS(NP), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .evtValid(evtValid), .evtData(evtData), .peerVecCount(peerVecCount),
    .maxPeer(maxPeer), .localId(localId), .shmMapped(shmMapped),
    .irq(irq), .notifyValid(notifyValid), .notifyDest(notifyDest),
    .notifyVec(notifyVec)
  );

  // Doorbell table: {write data, expect accepted}
  localparam int NBELL = 11;
  localparam logic [32:0] BELLS [NBELL] = '{
    {32'h0000_0000, 1'b1},  // peer0 vec0, count 1
    {32'h0000_0001, 1'b0},  // vec == count
    {32'h0001_0001, 1'b1},  // peer1 last legal vec
    {32'h0001_0002, 1'b0},  // vec == count
    {32'h0002_0000, 1'b0},  // peer2 count zero
    {32'h0003_0003, 1'b1},  // peer3 last legal vec
    {32'h0003_FF03, 1'b1},  // bits 15:8 ignored
    {32'h0005_0002, 1'b1},  // peer5 == maxPeer
    {32'h0006_0000, 1'b0},  // above maxPeer
    {32'h0100_0000, 1'b0},  // far above maxPeer
    {32'h0004_0100, 1'b1}   // vec 0 with junk in 15:8
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic pulseEvt(input logic [7:0] v);
    @(negedge clk);
    evtValid = 1'b1; evtData = v;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  task automatic ring(input logic [31:0] d, input bit expOk, input string tag);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 8'h0C; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
    chk(notifyValid == expOk, tag, {31'd0, notifyValid}, {31'd0, expOk});
    if (expOk) begin
      chk(notifyDest == d[31:16], {tag, " dest"}, {16'd0, notifyDest}, {16'd0, d[31:16]});
      chk(notifyVec == d[7:0], {tag, " vec"}, {24'd0, notifyVec}, {24'd0, d[7:0]});
    end
    @(negedge clk);
    chk(notifyValid == 1'b0, "R7 one-clock pulse", {31'd0, notifyValid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rstN = 1'b0; busSel = 1'b0; busWrite = 1'b0; busAddr = '0; busWdata = '0;
    evtValid = 1'b0; evtData = '0;
    peerVecCount = 64'h0303030304000201;
    maxPeer = 16'd5; localId = 16'h0025; shmMapped = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1;
    chk(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'd0);
    chk(notifyValid == 1'b0, "R1 notify", {31'd0, notifyValid}, 32'd0);
    doRead(8'h00, rd); chk(rd == 32'd0, "R1 mask", rd, 32'd0);
    doRead(8'h04, rd); chk(rd == 32'd0, "R1 status", rd, 32'd0);

    // R10 position
    doRead(8'h08, rd); chk(rd == 32'hFFFF_FFFF, "R10 unmapped", rd, 32'hFFFF_FFFF);
    shmMapped = 1'b1;
    doRead(8'h08, rd); chk(rd == 32'h25, "R10 mapped", rd, 32'h25);

    // R2 undefined / unaligned reads
    doRead(8'h0C, rd); chk(rd == 32'd0, "R2 bell read", rd, 32'd0);
    doRead(8'h40, rd); chk(rd == 32'd0, "R2 undefined", rd, 32'd0);

    // R3 writes ignore low bits
    doWrite(8'h03, 32'h0000_00F0);
    doRead(8'h00, rd); chk(rd == 32'hF0, "R3 mask via 0x03", rd, 32'hF0);
    doRead(8'h01, rd); chk(rd == 32'd0, "R2 unaligned read", rd, 32'd0);
    doWrite(8'h06, 32'h0000_0011);
    #1 chk(irq == 1'b1, "R4 overlap", {31'd0, irq}, 32'd1);

    // R5 read clears
    doRead(8'h04, rd); chk(rd == 32'h11, "R5 read value", rd, 32'h11);
    #1 chk(irq == 1'b0, "R5 irq dropped", {31'd0, irq}, 32'd0);
    doRead(8'h04, rd); chk(rd == 32'd0, "R5 cleared", rd, 32'd0);

    // R3 no effect writes
    doWrite(8'h08, 32'h1234_5678);
    doRead(8'h08, rd); chk(rd == 32'h25, "R3 pos write ignored", rd, 32'h25);
    doWrite(8'h20, 32'hFFFF_FFFF);
    doRead(8'h00, rd); chk(rd == 32'hF0, "R3 undefined write mask", rd, 32'hF0);
    doRead(8'h04, rd); chk(rd == 32'd0, "R3 undefined write status", rd, 32'd0);

    // R4 AND not OR
    doWrite(8'h04, 32'h0000_000F);
    #1 chk(irq == 1'b0, "R4 disjoint", {31'd0, irq}, 32'd0);
    doWrite(8'h00, 32'h0000_00FF);
    #1 chk(irq == 1'b1, "R4 mask enables", {31'd0, irq}, 32'd1);
    doWrite(8'h00, 32'h0);
    #1 chk(irq == 1'b0, "R4 mask disables", {31'd0, irq}, 32'd0);
    doRead(8'h04, rd);

    // R6 events
    pulseEvt(8'hA5);
    doRead(8'h04, rd); chk(rd == 32'hA5, "R6 event load", rd, 32'hA5);
    doWrite(8'h00, 32'h0000_00FF);
    pulseEvt(8'h00);
    #1 chk(irq == 1'b0, "R6 zero event", {31'd0, irq}, 32'd0);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 8'h04; busWdata = 32'h1234;
    evtValid = 1'b1; evtData = 8'h3C;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; evtValid = 1'b0;
    doRead(8'h04, rd); chk(rd == 32'h3C, "R6 event beats write", rd, 32'h3C);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = 8'h04;
    evtValid = 1'b1; evtData = 8'h77;
    #1 rd = busRdata;
    chk(rd == 32'd0, "R6 read before event", rd, 32'd0);
    @(negedge clk);
    busSel = 1'b0; evtValid = 1'b0;
    doRead(8'h04, rd); chk(rd == 32'h77, "R6 event beats clear", rd, 32'h77);
    #1 chk(irq == 1'b0, "R5 irq after read", {31'd0, irq}, 32'd0);

    // R7 R8 R9 doorbell table
    for (int i = 0; i < NBELL; i++) begin
      ring(BELLS[i][32:1], BELLS[i][0], $sformatf("R7/R8/R9 bell %0d", i));
    end

    // R8 table bound independent of maxPeer
    maxPeer = 16'hFFFF;
    ring(32'h0008_0000, 1'b0, "R8 beyond table");
    ring(32'h0007_0002, 1'b1, "R8 last table entry");
    // R9 count zero peer still blocked
    ring(32'h0002_0000, 1'b0, "R9 zero count");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule